// File: doc/BRIEF.md
# Priority Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core should take next. Four external request lines can each be set to edge or level sensitivity. Four internal event sources, two host-port read events and two host-port write events, are latched and then gated by two layers of masking. Every source has a fixed priority. The block presents the vector index of the winning request, together with a request flag. The core answers with an acknowledge strobe when it enters the service routine and with a return strobe when it leaves it.

A 5-bit control word holds the per-line sensitivity bits and a nesting-enable bit. A write to this word takes effect one cycle after the write. In non-nesting operation, a routine in service blocks every other request. In nesting operation, only a strictly higher-priority request can preempt the one in service. The nesting depth is limited to a parameterised stack of in-service levels.

The service tracker is a state machine with three states. `S_IDLE` means nothing is in service. `S_ACTIVE` means one or more routines are in service and the stack has room. `S_FULL` means the stack is full. The transitions are:
- enter: `S_IDLE` to `S_ACTIVE` on an accepted acknowledge.
- deepen: `S_ACTIVE` stays in `S_ACTIVE` on an accepted acknowledge below the last free slot.
- fill: `S_ACTIVE` to `S_FULL` on an accepted acknowledge into the last slot.
- unwind: `S_FULL` to `S_ACTIVE` on a return.
- pop: `S_ACTIVE` stays in `S_ACTIVE` on a return with more than one level in service.
- leave: `S_ACTIVE` to `S_IDLE` on the return of the last level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The control word is 5 bits wide. Bits 3:0 are the sensitivity of irq[3:0], where 0 means level and 1 means edge. Bit 4 enables nesting. After reset the effective word is 0: all lines are level-sensitive and nesting is off. Software is expected to program the word before relying on it.
- R2: A control write presented at clock edge k governs capture and arbitration only from clock edge k+1 onward. Until then the previous setting applies.
- R3: In edge mode, a line that was low in one cycle and high in the next sets that line's pending latch. The latch holds the request after the line drops, and stays set until the request is acknowledged.
- R4: In level mode nothing is latched. The request follows the line within the same cycle, so a line dropped before acknowledge loses the request. A line still high after the return is taken again.
- R5: An internal event pulse on int_evt[j] sets a pending latch, and the latch is kept while masked. The source competes only when int_mask[j]=1 and its class bit is 1. class_mask[0] gates the read sources j=0,1 (vectors 4,5). class_mask[1] gates the write sources j=2,3 (vectors 6,7).
- R6: Priority is fixed. Vectors 0..3 are irq[3:0] and vectors 4..7 are int_evt[3:0], and the lowest index wins. When int_req is 0, vector reads 8.
- R7: An ack while int_req=1 makes the presented vector the in-service level and clears that source's latch. If a new edge or event arrives on the same source in the ack cycle, the latch stays set.
- R8: With nesting off, int_req stays 0 while any routine is in service.
- R9: With nesting on, only a vector index below the current in-service index is requested. With 4 levels in service, int_req stays 0.
- R10: A return (rti) pops one in-service level. A return while idle is ignored. If rti and ack come in the same cycle, the return is performed and the ack is ignored.
- R11: An ack while int_req=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 4 | External request lines |
| int_evt | input | 4 | Internal event pulses (two reads, two writes) |
| int_mask | input | 4 | Per-source enable for internal events |
| class_mask | input | 2 | Class enable: bit 0 reads, bit 1 writes |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word: sensitivity 3:0, nesting 4 |
| ack | input | 1 | Core entered the service routine of the presented vector |
| rti | input | 1 | Core returned from the current routine |
| int_req | output | 1 | An eligible request is presented |
| vector | output | 4 | Winning vector index, 8 when none |

## Verification
Two pairs of events can fall in the same cycle. The first is an acknowledge that clears a pending latch while a fresh edge or event on that same source sets it again. The second is an acknowledge together with a return. Directed sequences drive each pair explicitly, and a seeded random phase raises acks, returns, events and control writes in overlapping cycles. In both cases the outcome is judged at the ports. The bench watches whether the source is offered again after the return, and whether the in-service depth reached via a single ack ends up where the requirement says.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_FULL   = 2'd2
    } svc_state_t;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int N_EXT = 4,
    parameter int N_INT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] irq,
    input  logic [N_INT-1:0] int_evt,
    input  logic             ctrl_we,
    input  logic [N_EXT:0]   ctrl_wdata,
    input  logic [N_EXT-1:0] clr_ext,
    input  logic [N_INT-1:0] clr_int,
    output logic [N_EXT-1:0] ext_req,
    output logic [N_INT-1:0] int_pend,
    output logic             nest_en
);
    logic [N_EXT:0]   ctrl_shadow;
    logic [N_EXT:0]   ctrl_eff;
    logic [N_EXT-1:0] irq_prev;
    logic [N_EXT-1:0] pend_ext;
    logic [N_EXT-1:0] sens;

    assign sens    = ctrl_eff[N_EXT-1:0];
    assign nest_en = ctrl_eff[N_EXT];

    // The written word sits in a shadow stage for one cycle before it governs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_shadow <= '0;
            ctrl_eff    <= '0;
            irq_prev    <= '0;
            pend_ext    <= '0;
            int_pend    <= '0;
        end else begin
            if (ctrl_we)
                ctrl_shadow <= ctrl_wdata;
            ctrl_eff <= ctrl_shadow;
            irq_prev <= irq;
            pend_ext <= sens & ((pend_ext & ~clr_ext) | (irq & ~irq_prev));
            int_pend <= (int_pend & ~clr_int) | int_evt;
        end
    end

    // Edge lines report their latch; level lines report the live pin.
    assign ext_req = (sens & pend_ext) | (~sens & irq);

    p_cfg_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ##1 (ctrl_eff == $past(ctrl_wdata, 2)));

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_ext & sens & ~clr_ext) & ~pend_ext) == '0));
endmodule

// File: rtl/irq_select.sv
module irq_select #(
    parameter int N_EXT = 4,
    parameter int N_INT = 4,
    parameter int VEC_W = 4
) (
    input  logic [N_EXT-1:0] ext_req,
    input  logic [N_INT-1:0] int_pend,
    input  logic [N_INT-1:0] int_mask,
    input  logic [1:0]       class_mask,
    input  logic             busy,
    input  logic             full,
    input  logic             nest_en,
    input  logic [VEC_W-1:0] top_lvl,
    output logic             int_req,
    output logic [VEC_W-1:0] vector
);
    localparam int N_SRC = N_EXT + N_INT;
    localparam logic [VEC_W-1:0] NONE = VEC_W'(N_SRC);

    logic [N_INT-1:0] cls_gate;
    logic [N_SRC-1:0] cand;
    logic             found;
    logic             allow;
    logic [VEC_W-1:0] pick;

    // Lower half of the internal sources are reads, upper half writes.
    for (genvar j = 0; j < N_INT; j++) begin : g_cls
        if (j < N_INT / 2) begin : g_rd
            assign cls_gate[j] = class_mask[0];
        end else begin : g_wr
            assign cls_gate[j] = class_mask[1];
        end
    end

    assign cand = {int_pend & int_mask & cls_gate, ext_req};

    always_comb begin
        found = 1'b0;
        pick  = NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                pick  = VEC_W'(i);
            end
        end
        allow   = !busy || (nest_en && !full && (pick < top_lvl));
        int_req = found && allow;
        vector  = int_req ? pick : NONE;
    end

    always_comb begin
        if (int_req) begin
            p_prio_r6: assert ((cand & ((N_SRC'(1) << vector) - N_SRC'(1))) == '0);
        end
    end
endmodule

// File: rtl/irq_service.sv
module irq_service
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int DEPTH = 4,
    parameter int VEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             rti,
    input  logic [VEC_W-1:0] vector,
    output logic             busy,
    output logic             full,
    output logic [VEC_W-1:0] top_lvl
);
    localparam int DW = $clog2(DEPTH + 1);
    localparam logic [DW-1:0] D_MAX = DW'(DEPTH);
    localparam logic [VEC_W-1:0] NONE = VEC_W'(N_SRC);

    svc_state_t       state, state_nx;
    logic [DW-1:0]    depth;
    logic [VEC_W-1:0] stk [DEPTH];
    logic             pop;
    logic             do_push;

    assign pop     = rti && (state != S_IDLE);
    assign do_push = push && !pop && (state != S_FULL);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (do_push)
                    state_nx = (D_MAX == DW'(1)) ? S_FULL : S_ACTIVE;
            end
            S_ACTIVE: begin
                if (pop)
                    state_nx = (depth == DW'(1)) ? S_IDLE : S_ACTIVE;
                else if (do_push)
                    state_nx = (depth == D_MAX - DW'(1)) ? S_FULL : S_ACTIVE;
            end
            S_FULL: begin
                if (pop)
                    state_nx = (D_MAX == DW'(1)) ? S_IDLE : S_ACTIVE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            depth <= '0;
        end else begin
            state <= state_nx;
            if (pop)
                depth <= depth - DW'(1);
            else if (do_push)
                depth <= depth + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                stk[i] <= NONE;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (do_push && depth == DW'(i))
                    stk[i] <= vector;
        end
    end

    always_comb begin
        busy    = (state != S_IDLE);
        full    = (state == S_FULL);
        top_lvl = NONE;
        for (int i = 0; i < DEPTH; i++)
            if (depth == DW'(i + 1))
                top_lvl = stk[i];
    end

    p_push_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> (depth == $past(depth) + DW'(1)));

    p_pop_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (depth == $past(depth) - DW'(1)));

    p_idle_rti_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && rti) |=> (state == S_IDLE));

    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= D_MAX);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_EXT = 4,
    parameter int N_INT = 4,
    parameter int DEPTH = 4,
    localparam int N_SRC = N_EXT + N_INT,
    localparam int VEC_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] irq,
    input  logic [N_INT-1:0] int_evt,
    input  logic [N_INT-1:0] int_mask,
    input  logic [1:0]       class_mask,
    input  logic             ctrl_we,
    input  logic [N_EXT:0]   ctrl_wdata,
    input  logic             ack,
    input  logic             rti,
    output logic             int_req,
    output logic [VEC_W-1:0] vector
);
    localparam logic [VEC_W-1:0] NONE = VEC_W'(N_SRC);

    logic [N_EXT-1:0] ext_req;
    logic [N_INT-1:0] int_pend;
    logic             nest_en;
    logic             busy, full;
    logic [VEC_W-1:0] top_lvl;
    logic             push;
    logic [N_SRC-1:0] clr_vec;

    // A return in the same cycle takes precedence over an acknowledge.
    assign push = ack && int_req && !rti;

    always_comb begin
        for (int i = 0; i < N_SRC; i++)
            clr_vec[i] = push && (vector == VEC_W'(i));
    end

    irq_capture #(.N_EXT(N_EXT), .N_INT(N_INT)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq        (irq),
        .int_evt    (int_evt),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .clr_ext    (clr_vec[N_EXT-1:0]),
        .clr_int    (clr_vec[N_SRC-1:N_EXT]),
        .ext_req    (ext_req),
        .int_pend   (int_pend),
        .nest_en    (nest_en)
    );

    irq_select #(.N_EXT(N_EXT), .N_INT(N_INT), .VEC_W(VEC_W)) u_select (
        .ext_req    (ext_req),
        .int_pend   (int_pend),
        .int_mask   (int_mask),
        .class_mask (class_mask),
        .busy       (busy),
        .full       (full),
        .nest_en    (nest_en),
        .top_lvl    (top_lvl),
        .int_req    (int_req),
        .vector     (vector)
    );

    irq_service #(.N_SRC(N_SRC), .DEPTH(DEPTH), .VEC_W(VEC_W)) u_service (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .rti     (rti),
        .vector  (vector),
        .busy    (busy),
        .full    (full),
        .top_lvl (top_lvl)
    );

    p_no_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !nest_en) |-> !int_req);

    p_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && busy) |-> (vector < top_lvl));

    p_full_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !int_req);

    p_idle_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> (vector == NONE));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/100ps
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq = '0;
    logic [3:0] int_evt = '0;
    logic [3:0] int_mask = '0;
    logic [1:0] class_mask = '0;
    logic       ctrl_we = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic       ack = 1'b0;
    logic       rti = 1'b0;
    logic       int_req;
    logic [3:0] vector;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .int_evt(int_evt),
        .int_mask(int_mask), .class_mask(class_mask), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .ack(ack), .rti(rti),
        .int_req(int_req), .vector(vector)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Requirement-level model of the controller.
    logic [4:0] m_sh, m_eff;
    logic [3:0] m_prev, m_pe, m_pi;
    logic [3:0] m_stk [4];
    int         m_dep;
    logic       exp_req;
    logic [3:0] exp_vec;

    function automatic void m_eval();
        logic [7:0] cand;
        logic       found;
        logic [3:0] pick;
        logic [3:0] top;
        for (int i = 0; i < 4; i++)
            cand[i] = m_eff[i] ? m_pe[i] : irq[i];
        for (int j = 0; j < 4; j++)
            cand[4+j] = m_pi[j] & int_mask[j] & ((j < 2) ? class_mask[0] : class_mask[1]);
        found = 1'b0;
        pick  = 4'd8;
        for (int i = 0; i < 8; i++)
            if (!found && cand[i]) begin
                found = 1'b1;
                pick  = 4'(i);
            end
        top = (m_dep > 0) ? m_stk[m_dep-1] : 4'd8;
        exp_req = found && ((m_dep == 0) || (m_eff[4] && m_dep < 4 && pick < top));
        exp_vec = exp_req ? pick : 4'd8;
    endfunction

    task automatic m_step();
        logic [7:0] clr;
        logic [4:0] eff_n;
        clr = '0;
        if (rti) begin
            if (m_dep > 0) m_dep--;
        end else if (ack && exp_req) begin
            m_stk[m_dep] = exp_vec;
            m_dep++;
            clr[exp_vec[2:0]] = 1'b1;
        end
        m_pe   = m_eff[3:0] & ((m_pe & ~clr[3:0]) | (irq & ~m_prev));
        m_pi   = (m_pi & ~clr[7:4]) | int_evt;
        m_prev = irq;
        eff_n  = m_sh;
        if (ctrl_we) m_sh = ctrl_wdata;
        m_eff = eff_n;
    endtask

    task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_now(string tag, logic req, logic [3:0] vec);
        #0.1;
        check(tag, "int_req", {3'b0, int_req}, {3'b0, req});
        check(tag, "vector", vector, vec);
    endtask

    // Called at a falling edge with inputs already driven.
    task automatic tick(string tag);
        #1;
        m_eval();
        check(tag, "int_req", {3'b0, int_req}, {3'b0, exp_req});
        check(tag, "vector", vector, exp_vec);
        m_step();
        @(negedge clk);
        ack = 1'b0; rti = 1'b0; ctrl_we = 1'b0; int_evt = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        m_sh = '0; m_eff = '0; m_prev = '0; m_pe = '0; m_pi = '0; m_dep = 0;
        for (int i = 0; i < 4; i++) m_stk[i] = 4'd8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1", 1'b0, 4'd8);

        // R4: level lines follow the pin; a dropped line is lost
        irq = 4'b0100; expect_now("R4", 1'b1, 4'd2); tick("R4");
        irq = 4'b0000; tick("R4");
        // R6: lowest index wins
        irq = 4'b1010; expect_now("R6", 1'b1, 4'd1); tick("R6");
        ack = 1'b1; tick("R7");
        // R8: non-nesting blocks even a higher line
        tick("R8");
        irq = 4'b0011; expect_now("R8", 1'b0, 4'd8); tick("R8");
        rti = 1'b1; tick("R10");
        expect_now("R4", 1'b1, 4'd0); tick("R4");
        irq = 4'b0000; tick("R4");

        // R2: switch line 0 to edge mode while it is held high
        irq = 4'b0001; tick("R2");
        ctrl_we = 1'b1; ctrl_wdata = 5'b00001; tick("R2");
        expect_now("R2", 1'b1, 4'd0); tick("R2");
        expect_now("R2", 1'b0, 4'd8); tick("R2");

        // R3: one-cycle pulse is captured and held
        irq = 4'b0000; tick("R3");
        irq = 4'b0001; tick("R3");
        irq = 4'b0000; expect_now("R3", 1'b1, 4'd0); tick("R3");
        expect_now("R3", 1'b1, 4'd0); tick("R3");
        ack = 1'b1; tick("R7");
        rti = 1'b1; tick("R10");
        expect_now("R3", 1'b0, 4'd8); tick("R3");

        // R7: event on the same source in its ack cycle keeps the latch
        class_mask = 2'b11; int_mask = 4'b0001; int_evt = 4'b0001; tick("R5");
        expect_now("R5", 1'b1, 4'd4);
        ack = 1'b1; int_evt = 4'b0001; tick("R7");
        rti = 1'b1; tick("R10");
        expect_now("R7", 1'b1, 4'd4);
        ack = 1'b1; tick("R7");
        rti = 1'b1; tick("R10");
        expect_now("R7", 1'b0, 4'd8); tick("R7");

        // R5: both mask layers needed
        int_evt = 4'b0100; class_mask = 2'b01; int_mask = 4'b0100; tick("R5");
        expect_now("R5", 1'b0, 4'd8);
        class_mask = 2'b10; int_mask = 4'b0000; expect_now("R5", 1'b0, 4'd8);
        int_mask = 4'b0100; expect_now("R5", 1'b1, 4'd6); tick("R5");
        ack = 1'b1; tick("R7");
        rti = 1'b1; tick("R10");

        // R11 and R10: stray ack, stray return, simultaneous ack and return
        ack = 1'b1; tick("R11");
        irq = 4'b0010; expect_now("R11", 1'b1, 4'd1);
        ack = 1'b1; rti = 1'b1; tick("R10");
        expect_now("R10", 1'b1, 4'd1);
        ack = 1'b1; tick("R7");
        irq = 4'b0000; rti = 1'b1; tick("R10");
        rti = 1'b1; tick("R10");
        expect_now("R10", 1'b0, 4'd8);

        // R9: nesting to full depth
        ctrl_we = 1'b1; ctrl_wdata = 5'b11111; tick("R9");
        tick("R9");
        class_mask = 2'b11; int_mask = 4'hF;
        int_evt = 4'b1000; tick("R9");
        ack = 1'b1; tick("R9");
        int_evt = 4'b1000; tick("R9");
        expect_now("R9", 1'b0, 4'd8);
        int_evt = 4'b0100; tick("R9");
        expect_now("R9", 1'b1, 4'd6);
        ack = 1'b1; tick("R9");
        int_evt = 4'b0010; tick("R9");
        ack = 1'b1; tick("R9");
        int_evt = 4'b0001; tick("R9");
        ack = 1'b1; tick("R9");
        irq = 4'b0001; tick("R9");
        irq = 4'b0000; expect_now("R9", 1'b0, 4'd8);
        rti = 1'b1; tick("R10");
        expect_now("R9", 1'b1, 4'd0);
        ack = 1'b1; tick("R9");
        repeat (4) begin rti = 1'b1; tick("R10"); end

        // Seeded random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 4 == 0) irq = 4'($urandom);
            if ($urandom % 6 == 0) int_evt = 4'($urandom) & 4'($urandom);
            if ($urandom % 40 == 0) int_mask = 4'($urandom);
            if ($urandom % 40 == 0) class_mask = 2'($urandom);
            if ($urandom % 60 == 0) begin
                ctrl_we = 1'b1;
                ctrl_wdata = 5'($urandom);
            end
            #0.1;
            m_eval();
            ack = (exp_req && ($urandom % 3 == 0)) || ($urandom % 29 == 0);
            rti = (m_dep > 0 && ($urandom % 5 == 0)) || ($urandom % 37 == 0);
            tick("R6");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule